// File: doc/BRIEF.md
# Vector Pack, Pick and Interleave Unit

This block rearranges the elements of two source vectors, called j and k, into one result vector for a SIMD datapath. Six permutations are offered: two that pack the even-indexed or odd-indexed elements of both sources pairwise, two that collect the even-indexed or odd-indexed elements of each source into contiguous halves, and two that interleave the lower or upper halves of the sources. Elements are 8, 16, 32 or 64 bits wide. The vector is either 128 bits (narrow) or 256 bits (wide). In wide mode the work is split into two independent 128-bit lanes. Each lane reads only the matching lane of j and k.

A request is presented with `in_valid` together with the sources and the three select inputs. The result, the illegal-operation flag and `out_valid` appear on the following clock edge. The result is then held until the next accepted request. Every output element is taken from the values sampled on the loading edge. A result can therefore be fed straight back as either source.

Top module: `vec_shuffle_unit`

## Requirements
- R1: Operation code 000 (pack-even): in each lane, result element 2i is element 2i of k, and result element 2i+1 is element 2i of j.
- R2: Operation code 001 (pack-odd): in each lane, result element 2i is element 2i+1 of k, and result element 2i+1 is element 2i+1 of j.
- R3: Operation codes 010 (pick-even) and 011 (pick-odd): in a lane of M elements, result element i for i < M/2 is element 2i (or 2i+1 for code 011) of k. Result element M/2+i is element 2i (or 2i+1) of j.
- R4: Operation codes 100 (interleave-low) and 101 (interleave-high): in a lane of M elements, result element 2i is element i of k and result element 2i+1 is element i of j, for i < M/2. Code 101 reads elements i+M/2 instead.
- R5: With `wide_mode`=1, result bits 255:128 depend only on bits 255:128 of j and k, and result bits 127:0 depend only on bits 127:0 of j and k.
- R6: `elem_size` selects the element width: 00 = 8 bits, 01 = 16 bits, 10 = 32 bits, 11 = 64 bits.
- R7: With `wide_mode`=0, result bits 255:128 are zero.
- R8: When `in_valid` is high on a rising edge, `out_valid` is high after that edge and the result reflects that request. When `in_valid` is low on an edge, `out_valid` is low after it and `result` keeps its value.
- R9: Synchronous active-high `rst` clears `out_valid`, `illegal_op` and `result`.
- R10: Operation codes 110 and 111 produce an all-zero result, and `illegal_op` is high for that one output cycle. `illegal_op` is low for legal codes and whenever `out_valid` is low.
- R11: The result is computed from the source values sampled on the loading edge, so passing the previous result as j and k gives the permutation of that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; loads the result register |
| op_sel | input | 3 | Operation code (see R1 to R4, R10) |
| elem_size | input | 2 | Element width code (see R6) |
| wide_mode | input | 1 | 1 = 256-bit vector, 0 = 128-bit vector |
| src_j | input | 256 | Source vector j |
| src_k | input | 256 | Source vector k |
| out_valid | output | 1 | Result valid, one cycle after a request |
| result | output | 256 | Permuted vector |
| illegal_op | output | 1 | Unused operation code was requested |

## Verification
The assertions assume that the select inputs and sources are stable across the edge where `in_valid` is sampled. They also assume that `rst` is held for at least one edge before any request. The bench drives every input on the falling edge and releases reset before the first request. It sweeps all eight operation codes, all four size codes and both widths with several distinct byte patterns. Each result is compared against a destination-indexed model written from the requirements.

// File: rtl/vsh_pkg.sv
package vsh_pkg;

    typedef enum logic [2:0] {
        OP_PACK_EVEN = 3'b000,
        OP_PACK_ODD  = 3'b001,
        OP_PICK_EVEN = 3'b010,
        OP_PICK_ODD  = 3'b011,
        OP_MERGE_LO  = 3'b100,
        OP_MERGE_HI  = 3'b101,
        OP_RSVD_6    = 3'b110,
        OP_RSVD_7    = 3'b111
    } shuf_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'b00,
        SZ_16 = 2'b01,
        SZ_32 = 2'b10,
        SZ_64 = 2'b11
    } elem_sz_e;

    typedef struct packed {
        shuf_op_e op;
        elem_sz_e sz;
        logic     wide;
    } shuf_ctl_t;

    localparam int NUM_SIZES = 4;

    function automatic int elem_bits(elem_sz_e sz);
        return 8 << int'(sz);
    endfunction

    function automatic logic op_is_legal(shuf_op_e op);
        return (op != OP_RSVD_6) && (op != OP_RSVD_7);
    endfunction

endpackage

// File: rtl/vsh_lane.sv
module vsh_lane
    import vsh_pkg::*;
#(
    parameter int LANE_BITS = 128
) (
    input  shuf_op_e               op,
    input  elem_sz_e               sz,
    input  logic [LANE_BITS-1:0]   src_j,
    input  logic [LANE_BITS-1:0]   src_k,
    output logic [LANE_BITS-1:0]   lane_out
);

    logic [LANE_BITS-1:0] by_size [NUM_SIZES];

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int EW   = elem_bits(elem_sz_e'(s));
        localparam int M    = LANE_BITS / EW;
        localparam int HALF = M / 2;

        logic [LANE_BITS-1:0] pk_ev, pk_od, pc_ev, pc_od, mg_lo, mg_hi;
        logic [LANE_BITS-1:0] chosen;

        always_comb begin
            pk_ev = '0;
            pk_od = '0;
            pc_ev = '0;
            pc_od = '0;
            mg_lo = '0;
            mg_hi = '0;
            for (int i = 0; i < HALF; i++) begin
                // pairwise pack: k in even slots, j in odd slots
                pk_ev[(2*i)*EW   +: EW] = src_k[(2*i)*EW   +: EW];
                pk_ev[(2*i+1)*EW +: EW] = src_j[(2*i)*EW   +: EW];
                pk_od[(2*i)*EW   +: EW] = src_k[(2*i+1)*EW +: EW];
                pk_od[(2*i+1)*EW +: EW] = src_j[(2*i+1)*EW +: EW];
                // gather: k fills the low half, j the high half
                pc_ev[i*EW        +: EW] = src_k[(2*i)*EW   +: EW];
                pc_ev[(i+HALF)*EW +: EW] = src_j[(2*i)*EW   +: EW];
                pc_od[i*EW        +: EW] = src_k[(2*i+1)*EW +: EW];
                pc_od[(i+HALF)*EW +: EW] = src_j[(2*i+1)*EW +: EW];
                // merge halves element by element
                mg_lo[(2*i)*EW   +: EW] = src_k[i*EW        +: EW];
                mg_lo[(2*i+1)*EW +: EW] = src_j[i*EW        +: EW];
                mg_hi[(2*i)*EW   +: EW] = src_k[(i+HALF)*EW +: EW];
                mg_hi[(2*i+1)*EW +: EW] = src_j[(i+HALF)*EW +: EW];
            end
        end

        always_comb begin
            unique case (op)
                OP_PACK_EVEN: chosen = pk_ev;
                OP_PACK_ODD:  chosen = pk_od;
                OP_PICK_EVEN: chosen = pc_ev;
                OP_PICK_ODD:  chosen = pc_od;
                OP_MERGE_LO:  chosen = mg_lo;
                OP_MERGE_HI:  chosen = mg_hi;
                default:      chosen = '0;
            endcase
        end

        assign by_size[s] = chosen;
    end

    assign lane_out = by_size[sz];

endmodule

// File: rtl/vsh_out_reg.sv
module vsh_out_reg #(
    parameter int W = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d_res,
    input  logic         d_bad,
    output logic         q_valid,
    output logic [W-1:0] q_res,
    output logic         q_bad
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_res   <= '0;
            q_bad   <= 1'b0;
        end else begin
            q_valid <= load;
            q_bad   <= load & d_bad;
            if (load) begin
                q_res <= d_res;
            end
        end
    end

    // R8
    load_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> q_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> (!q_valid && $stable(q_res)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!q_valid && !q_bad && q_res == '0));

    // R10
    flag_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !q_valid |-> !q_bad);

endmodule

// File: rtl/vec_shuffle_unit.sv
module vec_shuffle_unit
    import vsh_pkg::*;
#(
    parameter  int LANE_BITS = 128,
    parameter  int NUM_LANES = 2,
    localparam int VEC_BITS  = LANE_BITS * NUM_LANES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [2:0]          op_sel,
    input  logic [1:0]          elem_size,
    input  logic                wide_mode,
    input  logic [VEC_BITS-1:0] src_j,
    input  logic [VEC_BITS-1:0] src_k,
    output logic                out_valid,
    output logic [VEC_BITS-1:0] result,
    output logic                illegal_op
);

    shuf_ctl_t           ctl;
    logic [VEC_BITS-1:0] lane_raw;
    logic [VEC_BITS-1:0] next_res;
    logic                bad_code;

    assign ctl.op   = shuf_op_e'(op_sel);
    assign ctl.sz   = elem_sz_e'(elem_size);
    assign ctl.wide = wide_mode;

    assign bad_code = !op_is_legal(ctl.op);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        vsh_lane #(.LANE_BITS(LANE_BITS)) u_lane (
            .op       (ctl.op),
            .sz       (ctl.sz),
            .src_j    (src_j[g*LANE_BITS +: LANE_BITS]),
            .src_k    (src_k[g*LANE_BITS +: LANE_BITS]),
            .lane_out (lane_raw[g*LANE_BITS +: LANE_BITS])
        );
        if (g == 0) begin : g_base
            assign next_res[g*LANE_BITS +: LANE_BITS] = lane_raw[g*LANE_BITS +: LANE_BITS];
        end else begin : g_upper
            assign next_res[g*LANE_BITS +: LANE_BITS] =
                ctl.wide ? lane_raw[g*LANE_BITS +: LANE_BITS] : '0;
        end
    end

    vsh_out_reg #(.W(VEC_BITS)) u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .d_res   (next_res),
        .d_bad   (bad_code),
        .q_valid (out_valid),
        .q_res   (result),
        .q_bad   (illegal_op)
    );

    // R7
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_mode) |=> (result[VEC_BITS-1:LANE_BITS] == '0));

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel[2] && op_sel[1]) |=> (illegal_op && result == '0));

    // R10
    legal_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(op_sel[2] && op_sel[1])) |=> !illegal_op);

endmodule

// File: tb/vec_shuffle_unit_test.sv
`timescale 1ns/1ps
module vec_shuffle_unit_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   op_sel = '0;
    logic [1:0]   elem_size = '0;
    logic         wide_mode = 1'b0;
    logic [255:0] src_j = '0;
    logic [255:0] src_k = '0;
    logic         out_valid;
    logic [255:0] result;
    logic         illegal_op;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vec_shuffle_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .elem_size(elem_size), .wide_mode(wide_mode), .src_j(src_j),
        .src_k(src_k), .out_valid(out_valid), .result(result),
        .illegal_op(illegal_op)
    );

    function automatic logic [255:0] pattern(int seed, int which);
        logic [255:0] v;
        for (int b = 0; b < 32; b++) v[b*8 +: 8] = 8'(b*13 + seed*41 + which*97 + 5);
        return v;
    endfunction

    // destination-indexed model written from R1..R7, R10
    function automatic logic [255:0] model(int op, int sz, bit wide,
                                           logic [255:0] j, logic [255:0] k);
        logic [255:0] r = '0;
        int ew = 8 << sz;
        int m  = 128 / ew;
        int lanes = wide ? 2 : 1;
        if (op >= 6) return '0;
        for (int ln = 0; ln < lanes; ln++) begin
            for (int d = 0; d < m; d++) begin
                int  s = 0;
                bit  from_j = 1'b0;
                case (op)
                    0: begin from_j = d[0]; s = d[0] ? d - 1 : d; end
                    1: begin from_j = d[0]; s = d[0] ? d : d + 1; end
                    2: begin from_j = (d >= m/2); s = 2 * (d % (m/2)); end
                    3: begin from_j = (d >= m/2); s = 2 * (d % (m/2)) + 1; end
                    4: begin from_j = d[0]; s = d / 2; end
                    default: begin from_j = d[0]; s = d / 2 + m/2; end
                endcase
                for (int b = 0; b < ew; b++)
                    r[ln*128 + d*ew + b] = from_j ? j[ln*128 + s*ew + b] : k[ln*128 + s*ew + b];
            end
        end
        return r;
    endfunction

    function automatic string op_tag(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2, 3: return "R3";
            4, 5: return "R4";
            default: return "R10";
        endcase
    endfunction

    task automatic check_vec(string tag, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // drive one request, return at the falling edge after the loading edge
    task automatic issue(int op, int sz, bit wide, logic [255:0] j, logic [255:0] k);
        @(negedge clk);
        in_valid  = 1'b1;
        op_sel    = 3'(op);
        elem_size = 2'(sz);
        wide_mode = wide;
        src_j     = j;
        src_k     = k;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [255:0] j, k, prev, held;
        repeat (3) @(negedge clk);
        // R9 reset state
        check_bit("R9 out_valid after reset", out_valid, 1'b0);
        check_bit("R9 illegal_op after reset", illegal_op, 1'b0);
        check_vec("R9 result after reset", result, '0);
        rst = 1'b0;

        // sweep: R1 R2 R3 R4 R6 R7 R10
        for (int seed = 0; seed < 3; seed++) begin
            for (int op = 0; op < 8; op++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int w = 0; w < 2; w++) begin
                        string t;
                        j = pattern(seed, 1);
                        k = pattern(seed, 2);
                        issue(op, sz, w[0], j, k);
                        t = $sformatf("%s/R6 op=%0d sz=%0d wide=%0d", op_tag(op), op, sz, w);
                        check_vec(t, result, model(op, sz, w[0], j, k));
                        check_bit({"R8 valid ", t}, out_valid, 1'b1);
                        check_bit({"R10 flag ", t}, illegal_op, (op >= 6));
                        if (w == 0)
                            check_vec({"R7 upper ", t}, {128'd0, result[255:128]}, '0);
                    end
                end
            end
        end

        // R5: lower source lanes differ, upper lanes identical -> upper result identical
        j = pattern(7, 1);
        k = pattern(7, 2);
        issue(3, 0, 1'b1, j, k);
        prev = result;
        issue(3, 0, 1'b1, {j[255:128], ~j[127:0]}, {k[255:128], ~k[127:0]});
        check_vec("R5 upper lane isolated", {128'd0, result[255:128]}, {128'd0, prev[255:128]});
        check_vec("R5 lower lane model", result,
                  model(3, 0, 1'b1, {j[255:128], ~j[127:0]}, {k[255:128], ~k[127:0]}));

        // R8: idle cycle holds result and drops out_valid
        held = result;
        @(negedge clk);
        src_j = pattern(9, 3);
        src_k = pattern(9, 4);
        op_sel = 3'd4;
        @(negedge clk);
        check_bit("R8 out_valid low when idle", out_valid, 1'b0);
        check_vec("R8 result held when idle", result, held);
        check_bit("R10 flag low when idle", illegal_op, 1'b0);

        // R11: feed the previous result back as both sources
        issue(4, 1, 1'b1, pattern(11, 1), pattern(11, 2));
        prev = result;
        issue(2, 2, 1'b1, prev, prev);
        check_vec("R11 result as source", result, model(2, 2, 1'b1, prev, prev));

        // R9: reset after a valid result
        issue(0, 0, 1'b1, pattern(12, 1), pattern(12, 2));
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        op_sel = 3'd6;
        @(negedge clk);
        check_bit("R9 out_valid in reset", out_valid, 1'b0);
        check_bit("R9 illegal_op in reset", illegal_op, 1'b0);
        check_vec("R9 result in reset", result, '0);
        in_valid = 1'b0;
        rst = 1'b0;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule